// File: doc/BRIEF.md
# Clock Generator Control Register Slave (Two-Wire Serial)

This block is the serial control port of a clock generator. It is a slave on the standard-mode I2C bus. It holds a small bank of control bytes: byte 0 selects function and frequency, and every later byte is an output-enable mask in which a 1 lets the matching clock output run and a 0 stops it. The register bank appears on a flat output bus, and the output logic of the chip reads it from there.

Transfers carry no register offset. A host write sends the device address, then a command byte and a count byte. The slave acknowledges both of those bytes and throws their data away. The data bytes follow, and they fill the registers from byte 0 upwards until the host issues a stop. A host read sends the read address. The slave answers with a fixed byte count equal to the number of registers, and then sends the registers from byte 0 upwards.

Both bus lines are first passed through a two-flop synchronizer and a glitch filter. The state machine then runs on edge events in the system clock domain. Its states are ST_IDLE, ST_RX, ST_RX_END, ST_ACK, ST_TX and ST_TX_ACK, with these transitions:

- **Any state to ST_RX:** a start or repeated start, which also sets the phase back to the address byte and the write index to 0.
- **Any state to ST_IDLE:** a stop.
- **ST_IDLE:** waits for a start.
- **ST_RX:** shifts in one bit on each SCL rise. After the eighth bit it moves to ST_RX_END.
- **ST_RX_END:** on the next SCL fall it goes to ST_ACK. The one exception is an address byte that does not match, which goes to ST_IDLE.
- **ST_ACK:** holds SDA low for one bit. On the next SCL fall it moves to ST_TX after a read address, and to ST_RX otherwise.
- **ST_TX:** drives eight bits, each one changing on an SCL fall. Then it moves to ST_TX_ACK.
- **ST_TX_ACK:** samples the host acknowledge on the SCL rise. On the SCL fall it goes back to ST_TX if the host acknowledged, and to ST_IDLE if the host did not.

Top module: `clkgen_ctl_i2c`

## Requirements
- R1: Address matching:
  - Only the 7-bit address 0x69 is acknowledged. This appears as byte 0xD2 for a write and 0xD3 for a read, with the direction in bit 0.
  - Any other address byte is not acknowledged.
  - After a rejected address, the slave leaves SDA released until the next start.
- R2: Reset state:
  - After reset, byte 0 is 0x00 and bytes 1 to 5 are 0xFF.
  - Byte k appears on `ctl_regs_o[8k+7:8k]`.
- R3: Write sequence:
  - In a write, the two bytes after the address are acknowledged and their values are discarded.
  - Each following byte is acknowledged and stored at index 0, 1, 2, and so on, in the order received.
- R4: Stopping a write:
  - A stop may follow any complete byte.
  - A partly received byte is never stored.
  - Registers that were not written keep their values.
- R5: Data bytes past the last register are acknowledged but change no register.
- R6: Read sequence:
  - A read first returns the byte count 6.
  - Bytes 0 to 5 follow, most significant bit first.
  - Every byte after byte 5 reads as 0xFF.
- R7: Ending a read:
  - A host not-acknowledge ends a read, and the slave releases SDA.
  - The next transaction works normally.
- R8: A repeated start returns the slave to the address phase, and the next write or read begins again at byte 0.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 3) is ignored.
- R10: Bytes that follow a rejected address are neither acknowledged nor stored.
- R11: The slave pulls SDA low only in its acknowledge bit and in the 0 bits of read data. It never overrides a 1 that the host drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| ctl_regs_o | output | NUM_REGS*8 | Register bank, byte k at bits 8k+7:8k |

## Verification
Every write address byte with the direction bit clear is swept, so matching is shown to accept one value and no neighbour. The block write is then run with each data length from zero to eight bytes. Each pattern alternates complemented bytes and uses a different command and count value, so register positions, the discarded header bytes and the point where writing stops all show in the readback. Separate patterns cover:

- an aborted partial byte;
- a read ended early by a host not-acknowledge;
- back-to-back transfers joined by repeated starts;
- pulses two clocks wide on each line, which tell the filter threshold apart from genuine edges.

// File: rtl/clkgen_ctl_pkg.sv
package clkgen_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_ACK,
        ST_TX,
        ST_TX_ACK
    } ctl_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } ctl_phase_t;

endpackage

// File: rtl/clkgen_ctl_deglitch.sv
module clkgen_ctl_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          clean_q;

    // The output follows the synchronized input only after FILT_LEN
    // consecutive samples disagree with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                clean_q <= sync_q[1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean_o = clean_q;
endmodule

// File: rtl/clkgen_ctl_events.sv
module clkgen_ctl_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign start_o    = scl_q && scl_i && sda_q && !sda_i;
    assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
    assign scl_rise_o = !scl_q && scl_i;
    assign scl_fall_o = scl_q && !scl_i;
endmodule

// File: rtl/clkgen_ctl_regs.sv
module clkgen_ctl_regs #(
    parameter int         NUM_REGS = 6,
    parameter int         IDX_W    = 3,
    parameter logic [7:0] FREQ_RST = 8'h00,
    parameter logic [7:0] MASK_RST = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    input  logic [IDX_W-1:0]      rd_idx_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        localparam logic [7:0] RST_VAL = (g == 0) ? FREQ_RST : MASK_RST;
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                q <= wr_data_i;
            end
        end

        assign regs_o[g*8 +: 8] = q;
    end

    // Indices past the last register read as all ones.
    always_comb begin
        rd_data_o = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_data_o = regs_o[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/clkgen_ctl_fsm.sv
module clkgen_ctl_fsm
    import clkgen_ctl_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter int         IDX_W    = 3,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic [7:0]       rd_data_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_pull_o,
    output ctl_state_t       state_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS);

    ctl_state_t       state_q;
    ctl_phase_t       phase_q;
    logic             rw_q;
    logic             host_ack_q;
    logic [2:0]       bit_q;
    logic [7:0]       rx_sh_q;
    logic [7:0]       tx_sh_q;
    logic [IDX_W-1:0] wr_idx_q;
    logic [IDX_W-1:0] wr_at_q;
    logic [IDX_W-1:0] rd_idx_q;
    logic             wr_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_ADDR;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            bit_q      <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '1;
            wr_idx_q   <= '0;
            wr_at_q    <= '0;
            rd_idx_q   <= '0;
            wr_en_q    <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_i) begin
                state_q  <= ST_RX;
                phase_q  <= PH_ADDR;
                bit_q    <= '0;
                wr_idx_q <= '0;
            end else if (stop_i) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_RX: begin
                        if (scl_rise_i) begin
                            rx_sh_q <= {rx_sh_q[6:0], sda_i};
                            bit_q   <= bit_q + 3'd1;
                            if (bit_q == 3'd7) state_q <= ST_RX_END;
                        end
                    end
                    ST_RX_END: begin
                        if (scl_fall_i) begin
                            unique case (phase_q)
                                PH_ADDR: begin
                                    if (rx_sh_q[7:1] == DEV_ADDR) begin
                                        state_q <= ST_ACK;
                                        rw_q    <= rx_sh_q[0];
                                        phase_q <= PH_CMD;
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                PH_CMD: begin
                                    state_q <= ST_ACK;
                                    phase_q <= PH_CNT;
                                end
                                PH_CNT: begin
                                    state_q <= ST_ACK;
                                    phase_q <= PH_DATA;
                                end
                                PH_DATA: begin
                                    state_q <= ST_ACK;
                                    if (wr_idx_q < LAST) begin
                                        wr_en_q  <= 1'b1;
                                        wr_at_q  <= wr_idx_q;
                                        wr_idx_q <= wr_idx_q + 1'b1;
                                    end
                                end
                                default: state_q <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall_i) begin
                            bit_q <= '0;
                            if (rw_q) begin
                                state_q  <= ST_TX;
                                tx_sh_q  <= 8'(NUM_REGS);
                                rd_idx_q <= '0;
                            end else begin
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall_i) begin
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd7) begin
                                state_q <= ST_TX_ACK;
                            end else begin
                                tx_sh_q <= {tx_sh_q[6:0], 1'b1};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise_i) host_ack_q <= !sda_i;
                        if (scl_fall_i) begin
                            if (host_ack_q) begin
                                state_q <= ST_TX;
                                tx_sh_q <= rd_data_i;
                                bit_q   <= '0;
                                if (rd_idx_q < LAST) rd_idx_q <= rd_idx_q + 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sda_pull_o = (state_q == ST_ACK) || ((state_q == ST_TX) && !tx_sh_q[7]);
        wr_en_o    = wr_en_q;
        wr_idx_o   = wr_at_q;
        wr_data_o  = rx_sh_q;
        rd_idx_o   = rd_idx_q;
        state_o    = state_q;
    end
endmodule

// File: rtl/clkgen_ctl_i2c.sv
module clkgen_ctl_i2c
    import clkgen_ctl_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         FILT_LEN = 3,
    parameter logic [7:0] FREQ_RST = 8'h00,
    parameter logic [7:0] MASK_RST = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] ctl_regs_o
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);

    logic [1:0]       line_raw;
    logic [1:0]       line_clean;
    logic             start_det;
    logic             stop_det;
    logic             scl_rise;
    logic             scl_fall;
    logic [7:0]       rd_data;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    ctl_state_t       fsm_state;

    assign line_raw = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        clkgen_ctl_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (line_raw[l]),
            .clean_o(line_clean[l])
        );
    end

    clkgen_ctl_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (line_clean[0]),
        .sda_i     (line_clean[1]),
        .start_o   (start_det),
        .stop_o    (stop_det),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    clkgen_ctl_fsm #(
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W),
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_i     (line_clean[1]),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .rd_data_i (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .sda_pull_o(sda_pull_o),
        .state_o   (fsm_state)
    );

    clkgen_ctl_regs #(
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W),
        .FREQ_RST(FREQ_RST),
        .MASK_RST(MASK_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(wr_data),
        .rd_idx_i (rd_idx),
        .rd_data_o(rd_data),
        .regs_o   (ctl_regs_o)
    );
endmodule

// File: rtl/clkgen_ctl_i2c_chk.sv
module clkgen_ctl_i2c_chk
    import clkgen_ctl_pkg::*;
#(
    parameter int REG_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input ctl_state_t       state,
    input logic             sda_pull,
    input logic             start_det,
    input logic             stop_det,
    input logic             wr_en,
    input logic [REG_W-1:0] regs
);
    // R1: an idle slave (also after a rejected address) leaves SDA alone
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    // R11: while receiving bits the slave never drives the line
    a_r11_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX) |-> !sda_pull);

    // R11: pulling only happens in acknowledge or transmit states
    a_r11_pull_states: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> ((state == ST_ACK) || (state == ST_TX)));

    // R4: registers change only through a write strobe
    a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R8: a start always reopens the address phase
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX));

    // R7: a stop always returns to idle
    a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));
endmodule

bind clkgen_ctl_i2c clkgen_ctl_i2c_chk #(.REG_W(NUM_REGS*8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .sda_pull (sda_pull_o),
    .start_det(start_det),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .regs     (ctl_regs_o)
);

// File: tb/clkgen_ctl_i2c_test.sv
module clkgen_ctl_i2c_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int NREG       = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic scl_d;
    logic sda_d;
    wire  sda_pull;
    wire  sda_line;
    wire [NREG*8-1:0] ctl_regs;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] exp_r [NREG];

    assign sda_line = sda_d & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_ctl_i2c uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_d),
        .sda_i     (sda_line),
        .sda_pull_o(sda_pull),
        .ctl_regs_o(ctl_regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_port(input string tag);
        for (int i = 0; i < NREG; i++) check(tag, ctl_regs[i*8 +: 8], exp_r[i]);
    endtask

    task automatic bus_start();
        sda_d = 1'b1; scl_d = 1'b1; tick(Q);
        sda_d = 1'b0; tick(Q);
        scl_d = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_d = 1'b1; tick(Q);
        scl_d = 1'b1; tick(Q);
        sda_d = 1'b0; tick(Q);
        scl_d = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_d = 1'b0; tick(Q);
        scl_d = 1'b1; tick(Q);
        sda_d = 1'b1; tick(Q);
    endtask

    // One bit; with glitch set, a two-clock SCL pulse precedes the real
    // rise and a two-clock SDA pulse sits inside the high phase.
    task automatic clock_bit(input logic drive, input logic glitch, output logic seen);
        sda_d = drive;
        if (glitch) begin
            tick(2); scl_d = 1'b1; tick(2); scl_d = 1'b0; tick(Q-4);
        end else tick(Q);
        scl_d = 1'b1;
        if (glitch) begin
            tick(2); sda_d = ~drive; tick(2); sda_d = drive; tick(Q-4);
        end else tick(Q);
        seen = sda_line;
        tick(Q);
        scl_d = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
        logic seen;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(b[i], glitch, seen);
            check("R11 host bit not overdriven", seen, b[i]);
        end
        clock_bit(1'b1, 1'b0, seen);
        ack = ~seen;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        logic seen;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, 1'b0, seen);
            b = {b[6:0], seen};
        end
        clock_bit(~host_ack, 1'b0, seen);
    endtask

    task automatic full_read(input string tag);
        logic       ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, 1'b0, ack);
        check({tag, " R1 read address acked"}, ack, 1'b1);
        recv_byte(1'b1, b);
        check({tag, " R6 byte count"}, b, 8'd6);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(1'b1, b);
            check({tag, " R6 register readback"}, b, exp_r[i]);
        end
        recv_byte(1'b0, b);
        check({tag, " R6 past end reads FF"}, b, 8'hFF);
        bus_stop();
        check({tag, " R7 released after read"}, sda_pull, 1'b0);
    endtask

    initial begin
        logic       ack;
        logic [7:0] b;
        logic       seen;

        rst_n = 1'b0; scl_d = 1'b1; sda_d = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        exp_r[0] = 8'h00;
        for (int i = 1; i < NREG; i++) exp_r[i] = 8'hFF;
        check_port("R2 reset value");
        check("R11 released after reset", sda_pull, 1'b0);

        // R1: sweep every write address
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({a[6:0], 1'b0}, 1'b0, ack);
            bus_stop();
            check("R1 address match", ack, (a == 8'h69));
        end
        check_port("R3 address-only write leaves registers");

        // R10: traffic after a rejected address
        bus_start();
        send_byte(8'hD4, 1'b0, ack);
        check("R10 foreign address nacked", ack, 1'b0);
        foreach (exp_r[i]) begin
            send_byte(8'h12 + 8'(i), 1'b0, ack);
            check("R10 later byte nacked", ack, 1'b0);
        end
        bus_stop();
        check_port("R10 registers untouched");

        // R3/R4/R5: block writes of every length 0..8
        for (int len = 0; len <= 8; len++) begin
            bus_start();
            send_byte(8'hD2, 1'b0, ack);
            check("R1 write address acked", ack, 1'b1);
            send_byte(8'(len * 17 + 3), 1'b0, ack);
            check("R3 command byte acked", ack, 1'b1);
            send_byte(8'(len * 29 + 1), 1'b0, ack);
            check("R3 count byte acked", ack, 1'b1);
            for (int i = 0; i < len; i++) begin
                b = 8'(len * 53 + i * 29 + 7) ^ ((i % 2 == 1) ? 8'hFF : 8'h00);
                send_byte(b, 1'b0, ack);
                check((i < NREG) ? "R3 data byte acked" : "R5 extra byte acked", ack, 1'b1);
                if (i < NREG) exp_r[i] = b;
            end
            bus_stop();
            check_port((len <= NREG) ? "R4 stop after complete byte" : "R5 extra bytes discarded");
            full_read("sweep");
        end

        // R4: partial byte abandoned by stop
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h3C, 1'b0, ack);
        check("R4 first byte acked", ack, 1'b1);
        for (int i = 0; i < 4; i++) clock_bit(i[0], 1'b0, seen);
        bus_stop();
        exp_r[0] = 8'h3C;
        check_port("R4 partial byte not stored");

        // R7: host ends read early
        bus_start();
        send_byte(8'hD3, 1'b0, ack);
        recv_byte(1'b1, b);
        check("R7 count before early nack", b, 8'd6);
        recv_byte(1'b0, b);
        check("R7 byte0 before early nack", b, exp_r[0]);
        tick(Q);
        check("R7 released after host nack", sda_pull, 1'b0);
        bus_stop();
        full_read("R7 next read");

        // R8: repeated start between write and read
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'hEE, 1'b0, ack);
        send_byte(8'hEE, 1'b0, ack);
        send_byte(8'h5A, 1'b0, ack);
        send_byte(8'hA5, 1'b0, ack);
        exp_r[0] = 8'h5A; exp_r[1] = 8'hA5;
        bus_rstart();
        send_byte(8'hD3, 1'b0, ack);
        check("R8 read address after repeated start", ack, 1'b1);
        recv_byte(1'b1, b);
        check("R8 count after repeated start", b, 8'd6);
        recv_byte(1'b1, b);
        check("R8 byte0 after repeated start", b, 8'h5A);
        recv_byte(1'b0, b);
        check("R8 byte1 after repeated start", b, 8'hA5);
        bus_stop();

        // R8: repeated start between two writes restarts at byte 0
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'h01, 1'b0, ack);
        send_byte(8'h02, 1'b0, ack);
        send_byte(8'h11, 1'b0, ack);
        bus_rstart();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'h01, 1'b0, ack);
        send_byte(8'h02, 1'b0, ack);
        send_byte(8'h22, 1'b0, ack);
        bus_stop();
        exp_r[0] = 8'h22;
        check_port("R8 write index restarts");

        // R9: short pulses on both lines during a data byte
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'hC3, 1'b1, ack);
        check("R9 glitched byte acked", ack, 1'b1);
        send_byte(8'h96, 1'b1, ack);
        check("R9 second glitched byte acked", ack, 1'b1);
        bus_stop();
        exp_r[0] = 8'hC3; exp_r[1] = 8'h96;
        check_port("R9 glitches ignored");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule